// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

The block merges the four level-sensitive interrupt pins of several devices onto four shared interrupt outputs. Some devices sit directly on the root bus. Others sit behind a single bridge, and their pins are first rotated by their own slot number and then by the bridge's slot number before they reach an output. A registered copy of every pin level is kept. Each cycle, only pins whose level differs from that copy adjust the counter of the output they route to. An output is high while its counter is above zero, so an output stays asserted as long as any one of its sources is still asserted.

The counters are visible at the ports so that system state can be captured. They can also be loaded back through a restore request. A restore is accepted only when it describes the same number of outputs as the block has and every value fits the number of sources. Otherwise it is refused and a one-cycle reject flag is raised.

Top module: `shirq_agg`

## Requirements
- R1: Every device has four pins, bit p of its nibble being pin p. Reset clears all stored pin levels and counters, so the outputs are low and the reject flag is 0.
- R2: A pin whose new level equals its stored level leaves every counter unchanged.
- R3: On the clock edge after a pin rises, its routed counter goes up by one. On the clock edge after a pin falls, its routed counter goes down by one. The stored level follows the pin.
- R4: `irq_out[o]` is 1 exactly when counter o is nonzero.
- R5: Pin p of root device d routes to output (p + slot) mod 4. The slot is the low two bits of field d of `root_slot`.
- R6: Pin p of bridged device d is first rotated to bridge pin q = (p + its slot) mod 4. It then routes to output (q + `bridge_slot`) mod 4.
- R7: When several pins change in one cycle, each counter moves by the net sum of its rises and falls.
- R8: Counter o is at `irq_count[o*CW +: CW]`, with CW = clog2(sources+1). No counter exceeds the number of sources.
- R9: A restore with `load_nout` = 4 and every field of `load_counts` at most the source count is accepted. On the next edge the counters take the loaded values, and pin changes in that cycle update only the stored levels. Any other restore is refused: the counters update normally and `load_reject` is 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_pins | input | 4*N_ROOT | Pin levels of root-bus devices, nibble per device |
| root_slot | input | SLOT_W*N_ROOT | Slot number of each root-bus device |
| sub_pins | input | 4*N_SUB | Pin levels of devices behind the bridge |
| sub_slot | input | SLOT_W*N_SUB | Slot number of each bridged device |
| bridge_slot | input | SLOT_W | Slot number of the bridge on the root bus |
| load_en | input | 1 | Restore request |
| load_nout | input | 8 | Output count carried by the restore |
| load_counts | input | 4*CW | Counter values to restore |
| irq_out | output | 4 | Shared interrupt levels |
| irq_count | output | 4*CW | Counter values |
| load_reject | output | 1 | Restore refused last cycle |

## Verification
On every cycle, the assertions check three things: the stored levels follow the pins with one cycle of delay, a cycle with no pin difference and no restore keeps the counters still, and a counter never goes past the source count. They also confirm that a restore with a wrong output count raises the reject flag. The routing arithmetic through the bridge, the net adjustment when rises and falls land together, and the accepted-restore override can only be shown by the bench's scenarios. The bench checks them against its own reference model.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
    localparam int PINS = 4;

    // rotate a pin index by a slot number, modulo the pin count
    function automatic logic [1:0] rotate(input logic [1:0] pin, input logic [1:0] slot);
        return pin + slot;
    endfunction
endpackage

// File: rtl/shirq_route.sv
module shirq_route
    import shirq_pkg::*;
#(
    parameter int N_ROOT = 3,
    parameter int N_SUB  = 2,
    parameter int SLOT_W = 5,
    localparam int NSRC  = PINS * (N_ROOT + N_SUB)
) (
    input  logic [SLOT_W*N_ROOT-1:0] root_slot,
    input  logic [SLOT_W*N_SUB-1:0]  sub_slot,
    input  logic [SLOT_W-1:0]        bridge_slot,
    output logic [2*NSRC-1:0]        dest
);
    for (genvar d = 0; d < N_ROOT; d++) begin : g_root
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            assign dest[2*(d*PINS+p) +: 2] = rotate(2'(p), root_slot[d*SLOT_W +: 2]);
        end
    end

    for (genvar d = 0; d < N_SUB; d++) begin : g_sub
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            logic [1:0] bridge_pin;
            assign bridge_pin = rotate(2'(p), sub_slot[d*SLOT_W +: 2]);
            assign dest[2*((N_ROOT+d)*PINS+p) +: 2] = rotate(bridge_pin, bridge_slot[1:0]);
        end
    end
endmodule

// File: rtl/shirq_tally.sv
module shirq_tally #(
    parameter int NSRC = 20,
    parameter int NOUT = 4,
    parameter int CW   = 5
) (
    input  logic [NSRC-1:0]    rise,
    input  logic [NSRC-1:0]    fall,
    input  logic [2*NSRC-1:0]  dest,
    input  logic [NOUT*CW-1:0] cnt_in,
    output logic [NOUT*CW-1:0] cnt_out
);
    always_comb begin
        for (int o = 0; o < NOUT; o++) begin
            logic [CW-1:0] acc;
            acc = cnt_in[o*CW +: CW];
            for (int i = 0; i < NSRC; i++) begin
                if (dest[2*i +: 2] == 2'(o)) begin
                    if (rise[i]) acc = acc + CW'(1);
                    if (fall[i]) acc = acc - CW'(1);
                end
            end
            cnt_out[o*CW +: CW] = acc;
        end
    end
endmodule

// File: rtl/shirq_agg.sv
module shirq_agg
    import shirq_pkg::*;
#(
    parameter int N_ROOT = 3,
    parameter int N_SUB  = 2,
    parameter int SLOT_W = 5,
    localparam int NSRC  = PINS * (N_ROOT + N_SUB),
    localparam int NOUT  = PINS,
    localparam int CW    = $clog2(NSRC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [PINS*N_ROOT-1:0]   root_pins,
    input  logic [SLOT_W*N_ROOT-1:0] root_slot,
    input  logic [PINS*N_SUB-1:0]    sub_pins,
    input  logic [SLOT_W*N_SUB-1:0]  sub_slot,
    input  logic [SLOT_W-1:0]        bridge_slot,
    input  logic                     load_en,
    input  logic [7:0]               load_nout,
    input  logic [NOUT*CW-1:0]       load_counts,
    output logic [NOUT-1:0]          irq_out,
    output logic [NOUT*CW-1:0]       irq_count,
    output logic                     load_reject
);
    typedef struct packed {
        logic [NSRC-1:0]    st;
        logic [NOUT*CW-1:0] cnt;
        logic               rej;
    } regs_t;

    regs_t r_d, r_q;

    logic [NSRC-1:0]    pins_all;
    logic [NSRC-1:0]    rise, fall;
    logic [2*NSRC-1:0]  dest;
    logic [NOUT*CW-1:0] tally_cnt;
    logic               load_ok;

    assign pins_all = {sub_pins, root_pins};
    assign rise     = pins_all & ~r_q.st;
    assign fall     = ~pins_all & r_q.st;

    shirq_route #(.N_ROOT(N_ROOT), .N_SUB(N_SUB), .SLOT_W(SLOT_W)) u_route (
        .root_slot   (root_slot),
        .sub_slot    (sub_slot),
        .bridge_slot (bridge_slot),
        .dest        (dest)
    );

    shirq_tally #(.NSRC(NSRC), .NOUT(NOUT), .CW(CW)) u_tally (
        .rise    (rise),
        .fall    (fall),
        .dest    (dest),
        .cnt_in  (r_q.cnt),
        .cnt_out (tally_cnt)
    );

    always_comb begin
        load_ok = (load_nout == 8'(NOUT));
        for (int o = 0; o < NOUT; o++) begin
            if (load_counts[o*CW +: CW] > CW'(NSRC)) load_ok = 1'b0;
        end
    end

    always_comb begin
        r_d     = r_q;
        r_d.st  = pins_all;
        r_d.rej = load_en && !load_ok;
        r_d.cnt = (load_en && load_ok) ? load_counts : tally_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    for (genvar o = 0; o < NOUT; o++) begin : g_out
        assign irq_out[o] = |r_q.cnt[o*CW +: CW];
    end
    assign irq_count   = r_q.cnt;
    assign load_reject = r_q.rej;
endmodule

// File: rtl/shirq_agg_chk.sv
module shirq_agg_chk #(
    parameter int NSRC = 20,
    parameter int NOUT = 4,
    parameter int CW   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NSRC-1:0]    pins_all,
    input logic [NSRC-1:0]    state_q,
    input logic               load_en,
    input logic [7:0]         load_nout,
    input logic [NOUT*CW-1:0] irq_count,
    input logic               load_reject
);
    AST_STATE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> state_q == $past(pins_all)); // R3

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == pins_all && !load_en) |=> $stable(irq_count)); // R2

    AST_BAD_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && load_nout != 8'(NOUT)) |=> load_reject); // R9

    for (genvar o = 0; o < NOUT; o++) begin : g_cnt
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            irq_count[o*CW +: CW] <= CW'(NSRC)); // R8
    end
endmodule

bind shirq_agg shirq_agg_chk #(.NSRC(NSRC), .NOUT(NOUT), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_all    ({sub_pins, root_pins}),
    .state_q     (r_q.st),
    .load_en     (load_en),
    .load_nout   (load_nout),
    .irq_count   (irq_count),
    .load_reject (load_reject)
);

// File: tb/shirq_agg_bench.sv
`timescale 1ns/1ps
module shirq_agg_bench;
    localparam int N_ROOT = 3;
    localparam int N_SUB  = 2;
    localparam int SLOT_W = 5;
    localparam int NSRC   = 4 * (N_ROOT + N_SUB);
    localparam int CW     = $clog2(NSRC + 1);
    localparam int EW     = 4 + 4*CW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4*N_ROOT-1:0]      root_pins = '0;
    logic [SLOT_W*N_ROOT-1:0] root_slot;
    logic [4*N_SUB-1:0]       sub_pins = '0;
    logic [SLOT_W*N_SUB-1:0]  sub_slot;
    logic [SLOT_W-1:0]        bridge_slot;
    logic                     load_en = 1'b0;
    logic [7:0]               load_nout = '0;
    logic [4*CW-1:0]          load_counts = '0;
    logic [3:0]               irq_out;
    logic [4*CW-1:0]          irq_count;
    logic                     load_reject;

    always #4 clk = ~clk;

    shirq_agg #(.N_ROOT(N_ROOT), .N_SUB(N_SUB), .SLOT_W(SLOT_W)) u_shirq_agg (
        .clk(clk), .rst_n(rst_n), .root_pins(root_pins), .root_slot(root_slot),
        .sub_pins(sub_pins), .sub_slot(sub_slot), .bridge_slot(bridge_slot),
        .load_en(load_en), .load_nout(load_nout), .load_counts(load_counts),
        .irq_out(irq_out), .irq_count(irq_count), .load_reject(load_reject)
    );

    int rsl[N_ROOT] = '{0, 1, 2};
    int ssl[N_SUB]  = '{1, 3};
    int bsl = 2;
    int st[NSRC];
    int cnt[4];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    function automatic int dest_of(int i);
        int j;
        if (i < N_ROOT*4) return (i % 4 + rsl[i/4]) % 4;
        j = i - N_ROOT*4;
        return ((j % 4 + ssl[j/4]) % 4 + bsl) % 4;
    endfunction

    function automatic logic [EW-1:0] pack_exp(bit rej);
        logic [EW-1:0] e;
        e[0] = rej;
        for (int o = 0; o < 4; o++) begin
            e[1 + o*CW +: CW] = CW'(cnt[o]);
            e[1 + 4*CW + o]   = (cnt[o] != 0);
        end
        return e;
    endfunction

    task automatic step(input logic [4*N_ROOT-1:0] rp, input logic [4*N_SUB-1:0] sp,
                        input bit le, input int nout, input int lc[4], input string tag);
        logic [NSRC-1:0] all;
        bit ok;
        @(negedge clk);
        root_pins = rp;
        sub_pins  = sp;
        load_en   = le;
        load_nout = 8'(nout);
        for (int o = 0; o < 4; o++) load_counts[o*CW +: CW] = CW'(lc[o]);
        all = {sp, rp};
        ok = le && (nout == 4);
        for (int o = 0; o < 4; o++) if (lc[o] > NSRC) ok = 0;
        for (int i = 0; i < NSRC; i++) begin
            if (!ok && int'(all[i]) != st[i]) cnt[dest_of(i)] += all[i] ? 1 : -1;
            st[i] = int'(all[i]);
        end
        if (ok) for (int o = 0; o < 4; o++) cnt[o] = lc[o];
        exp_q.push_back(pack_exp(le && !ok));
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [EW-1:0] e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {irq_out, irq_count, load_reject};
            compared++;
            if (a !== e) begin
                mismatched++;
                $display("FAIL %s: actual out=%b cnt=%h rej=%b expected out=%b cnt=%h rej=%b",
                         t, a[EW-1 -: 4], a[4*CW:1], a[0], e[EW-1 -: 4], e[4*CW:1], e[0]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int z[4] = '{0, 0, 0, 0};
        int bad[4] = '{1, 1, 1, 1};
        int good[4] = '{3, 0, 1, 2};
        for (int d = 0; d < N_ROOT; d++) root_slot[d*SLOT_W +: SLOT_W] = SLOT_W'(rsl[d]);
        for (int d = 0; d < N_SUB; d++)  sub_slot[d*SLOT_W +: SLOT_W]  = SLOT_W'(ssl[d]);
        bridge_slot = SLOT_W'(bsl);
        for (int i = 0; i < NSRC; i++) st[i] = 0;
        for (int o = 0; o < 4; o++) cnt[o] = 0;
        repeat (3) @(posedge clk);
        #2;
        compared++;
        if (irq_out !== 4'b0 || irq_count !== '0 || load_reject !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 reset: actual out=%b cnt=%h rej=%b expected 0", irq_out, irq_count, load_reject);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R5: root dev0 slot0 pin0 -> out0
        step(12'h001, 8'h00, 0, 0, z, "R5 root dev0 pin0");
        // R2: same levels again, nothing moves
        step(12'h001, 8'h00, 0, 0, z, "R2 repeat level");
        // R5/R4: root dev1 slot1 pin3 -> out0, count 2
        step(12'h081, 8'h00, 0, 0, z, "R5 root dev1 pin3");
        // R6: bridged dev0 slot1 pin2 -> q=3 -> out1
        step(12'h081, 8'h04, 0, 0, z, "R6 bridged dev0 pin2");
        // R6: bridged dev1 slot3 pin0 -> q=3 -> out1
        step(12'h081, 8'h14, 0, 0, z, "R6 bridged dev1 pin0");
        // R7: two rises and one fall together
        step(12'h380, 8'h14, 0, 0, z, "R7 simultaneous changes");
        step(12'h380, 8'h14, 0, 0, z, "R2 hold after mix");
        // R3/R4: everything falls
        step(12'h000, 8'h00, 0, 0, z, "R3 all fall R4 outputs low");
        // R9: wrong output count refused, counters still follow pins
        step(12'h002, 8'h00, 1, 3, bad, "R9 restore refused");
        // R9: out-of-range value refused
        step(12'h002, 8'h00, 1, 4, '{21, 0, 0, 0}, "R9 restore value too large");
        // R9: valid restore overrides a simultaneous pin rise
        step(12'h802, 8'h00, 1, 4, good, "R9 restore accepted");
        // R8: counters hold restored values
        step(12'h802, 8'h00, 0, 0, z, "R8 restored counts held");
        // R3: rise after restore adds on top
        step(12'h803, 8'h00, 0, 0, z, "R3 rise after restore");
        @(negedge clk);
        load_en = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule